// File: doc/BRIEF.md
# Beacon Activation and Reset Controller

This block decides whether an emergency beacon is transmitting. It watches two operator switches (a cockpit panel switch with the positions ARM and ON, and a switch on the unit itself with the positions OFF and ON), a signal saying the unit is secured in its mounting tray, and a pulse from the crash sensor. Its `active` output enables the crash-mode power domain and the transmit scheduler. It also drives a panel lamp that flashes while the beacon is active and a buzzer/LED enable.

The beacon starts in one of two ways. It starts by itself when the sensor fires while the unit is mounted and both switches are at rest. It also starts when an operator puts either switch to ON. An operator clears an accidental activation by flicking either switch to ON and back within a short window. A longer stay in ON counts as a deliberate manual activation and leaves the beacon on. A crash that arrives while such a flick is in progress is held, and it activates the beacon once the switches are back at rest.

Every input passes through a two-flop synchronizer. A change at a pin therefore reaches `active` on the third rising clock edge after the edge that first samples it.

Top module: `beacon_act_ctrl`

## Requirements
- R1: With `mounted`=1 and both switches at rest (`panelOn`=0 meaning ARM, `unitOn`=0 meaning OFF), a rising edge on `crashPulse` sets `active` to 1 on the third rising clock edge after the edge that first samples it.
- R2: A `crashPulse` rising edge while `mounted`=0 is ignored, and `active` stays 0.
- R3: Setting `panelOn` to 1 (ON) sets `active` to 1 with the same three-edge latency, whatever the state of `mounted`.
- R4: Setting `unitOn` to 1 (ON) sets `active` to 1 with the same three-edge latency.
- R5: If `panelOn` is held at 1 for at most QUICK_MAX sampled cycles and then returns to 0 while `unitOn` is 0, `active` becomes 0. The same applies when the activation came from a crash.
- R6: If `unitOn` is held at 1 for at most QUICK_MAX sampled cycles and then returns to 0 while `panelOn` is 0, `active` becomes 0.
- R7: A switch held at 1 for more than QUICK_MAX sampled cycles leaves `active` at 1 after it returns to 0.
- R8: A crash edge that arrives while `mounted`=1 and a switch is at 1 is held. When a quick return then completes with both switches at rest, `active` ends at 1 instead of 0.
- R9: `lamp` is 1 in the first cycle that `active` is 1. While `active` stays 1, `lamp` then alternates between FLASH_HALF cycles on and FLASH_HALF cycles off.
- R10: `lamp` is 0 whenever `active` is 0. `buzzer` equals `active`.
- R11: After reset, `active`, `lamp` and `buzzer` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| panelOn | input | 1 | Cockpit switch: 1 = ON, 0 = ARM |
| unitOn | input | 1 | Unit switch: 1 = ON, 0 = OFF |
| mounted | input | 1 | 1 when the unit is secured in its tray |
| crashPulse | input | 1 | Debounced crash sensor pulse; its rising edge is the event |
| active | output | 1 | Beacon active; enables crash-mode power and the transmit scheduler |
| lamp | output | 1 | Flashing panel lamp |
| buzzer | output | 1 | Buzzer/LED driver enable |

## Verification
The bench fires the crash sensor with the unit mounted and unmounted. This separates the automatic path from the mounting interlock. It flicks each switch with dwell times of exactly QUICK_MAX and QUICK_MAX+1, plus random dwells on both sides of that limit. These cases tell a reset gesture from a manual activation on each switch. One directed case fires the sensor in the middle of a flick, which exposes whether the held crash survives the cancel. The lamp is sampled at the first active cycle and at each half-period boundary, so any offset in the flash phase or period shows up.

// File: rtl/bac_pkg.sv
package bac_pkg;
  localparam int NUM_SW = 2;   // index 0 = panel switch, index 1 = unit switch

  // strobes from the datapath to the control
  typedef struct packed {
    logic [NUM_SW-1:0] swRise;
    logic [NUM_SW-1:0] swFallQuick;
    logic [NUM_SW-1:0] swFallSlow;
    logic [NUM_SW-1:0] swLevel;
    logic              crashEvt;
    logic              mountedLvl;
  } bacEvt_t;
endpackage

// File: rtl/bac_datapath.sv
module bac_datapath
  import bac_pkg::*;
#(
  parameter int QUICK_MAX  = 8,
  parameter int FLASH_HALF = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SW-1:0] swIn,
  input  logic              mountedIn,
  input  logic              crashIn,
  input  logic              activeI,
  output bacEvt_t           evt,
  output logic              lampPhase
);
  localparam int NUM_IN  = NUM_SW + 2;
  localparam int DWELL_W = $clog2(QUICK_MAX + 2);
  localparam int FLASH_W = $clog2(FLASH_HALF + 1);
  localparam logic [DWELL_W-1:0] DWELL_SAT  = DWELL_W'(QUICK_MAX + 1);
  localparam logic [DWELL_W-1:0] DWELL_LIM  = DWELL_W'(QUICK_MAX);
  localparam logic [FLASH_W-1:0] FLASH_LAST = FLASH_W'(FLASH_HALF - 1);

  logic [NUM_IN-1:0] rawIn, syncA, syncB;
  logic [NUM_SW-1:0] swPrev;
  logic              crashPrev;
  logic [NUM_SW-1:0] swNow;

  assign rawIn = {crashIn, mountedIn, swIn};
  assign swNow = syncB[NUM_SW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      swPrev    <= '0;
      crashPrev <= 1'b0;
    end else begin
      syncA     <= rawIn;
      syncB     <= syncA;
      swPrev    <= swNow;
      crashPrev <= syncB[NUM_SW+1];
    end
  end

  for (genvar gi = 0; gi < NUM_SW; gi++) begin : g_sw
    logic [DWELL_W-1:0] dwellCnt;
    logic               fallNow;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   dwellCnt <= '0;
      else if (!swNow[gi])         dwellCnt <= '0;
      else if (dwellCnt != DWELL_SAT) dwellCnt <= dwellCnt + 1'b1;
    end

    assign fallNow              = swPrev[gi] & ~swNow[gi];
    assign evt.swRise[gi]       = swNow[gi] & ~swPrev[gi];
    assign evt.swFallQuick[gi]  = fallNow & (dwellCnt <= DWELL_LIM);
    assign evt.swFallSlow[gi]   = fallNow & (dwellCnt >  DWELL_LIM);
    assign evt.swLevel[gi]      = swNow[gi];
  end

  assign evt.crashEvt   = syncB[NUM_SW+1] & ~crashPrev;
  assign evt.mountedLvl = syncB[NUM_SW];

  // flash timer: held in the "on" phase while the beacon is idle
  logic [FLASH_W-1:0] flashCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashCnt  <= '0;
      lampPhase <= 1'b1;
    end else if (!activeI) begin
      flashCnt  <= '0;
      lampPhase <= 1'b1;
    end else if (flashCnt == FLASH_LAST) begin
      flashCnt  <= '0;
      lampPhase <= ~lampPhase;
    end else begin
      flashCnt  <= flashCnt + 1'b1;
    end
  end
endmodule

// File: rtl/bac_control.sv
module bac_control
  import bac_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  bacEvt_t evt,
  output logic    activeO
);
  logic pendCrash;
  logic nxtActive, nxtPend;
  logic anyOn, anyFall, cancelReq;

  always_comb begin
    anyOn     = |evt.swLevel;
    anyFall   = |(evt.swFallQuick | evt.swFallSlow);
    cancelReq = (|evt.swFallQuick) & ~anyOn;
    nxtActive = activeO;
    nxtPend   = pendCrash;
    if (cancelReq) nxtActive = pendCrash;      // held crash overrides the cancel
    if (anyFall && !anyOn) nxtPend = 1'b0;
    if (|evt.swRise) nxtActive = 1'b1;
    if (evt.crashEvt && evt.mountedLvl) begin
      if (anyOn) nxtPend   = 1'b1;
      else       nxtActive = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeO   <= 1'b0;
      pendCrash <= 1'b0;
    end else begin
      activeO   <= nxtActive;
      pendCrash <= nxtPend;
    end
  end
endmodule

// File: rtl/beacon_act_ctrl.sv
module beacon_act_ctrl
  import bac_pkg::*;
#(
  parameter int QUICK_MAX  = 8,
  parameter int FLASH_HALF = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic panelOn,
  input  logic unitOn,
  input  logic mounted,
  input  logic crashPulse,
  output logic active,
  output logic lamp,
  output logic buzzer
);
  bacEvt_t evt;
  logic    lampPhase;

  bac_datapath #(.QUICK_MAX(QUICK_MAX), .FLASH_HALF(FLASH_HALF)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .swIn     ({unitOn, panelOn}),
    .mountedIn(mounted),
    .crashIn  (crashPulse),
    .activeI  (active),
    .evt      (evt),
    .lampPhase(lampPhase)
  );

  bac_control u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .evt    (evt),
    .activeO(active)
  );

  assign lamp   = active & lampPhase;
  assign buzzer = active;
endmodule

// File: rtl/bac_checker.sv
module bac_checker (
  input logic clk,
  input logic rstN,
  input logic panelOn,
  input logic unitOn,
  input logic crashPulse,
  input logic active,
  input logic lamp
);
  p_lamp_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !lamp);

  p_lamp_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> lamp);

  // R1 R3 R4 R8: activation needs a crash or a switch event a fixed number of cycles back
  p_rise_cause_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> ($past(crashPulse, 3) || $past(panelOn, 3) || $past(unitOn, 3)
                       || $past(panelOn, 4) || $past(unitOn, 4)));

  // R5 R6: deactivation only follows a switch that was at ON
  p_fall_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> ($past(panelOn, 4) || $past(unitOn, 4)));
endmodule

bind beacon_act_ctrl bac_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .panelOn   (panelOn),
  .unitOn    (unitOn),
  .crashPulse(crashPulse),
  .active    (active),
  .lamp      (lamp)
);

// File: tb/beacon_act_ctrl_tb.sv
module beacon_act_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QUICK = 8;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rstN, panelOn, unitOn, mounted, crashPulse;
  logic active, lamp, buzzer;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  beacon_act_ctrl #(.QUICK_MAX(QUICK), .FLASH_HALF(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .panelOn(panelOn), .unitOn(unitOn),
    .mounted(mounted), .crashPulse(crashPulse),
    .active(active), .lamp(lamp), .buzzer(buzzer)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic expAfterFlick(input int dwell);
    return (dwell > QUICK) ? 1'b1 : 1'b0;
  endfunction

  task automatic setSw(input int which, input logic v);
    if (which == 0) panelOn = v; else unitOn = v;
  endtask

  // hold a switch at ON for dwell cycles, release, wait until the result is visible
  task automatic flick(input int which, input int dwell);
    setSw(which, 1'b1);
    tick(dwell);
    setSw(which, 1'b0);
    tick(3);
  endtask

  task automatic crash();
    crashPulse = 1'b1;
    tick(1);
    crashPulse = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; panelOn = 1'b0; unitOn = 1'b0; mounted = 1'b1; crashPulse = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk(active, 1'b0, "R11 active after reset");
    chk(lamp,   1'b0, "R11 lamp after reset");
    chk(buzzer, 1'b0, "R11 buzzer after reset");

    // R2: unmounted crash ignored
    mounted = 1'b0;
    crash();
    chk(active, 1'b0, "R2 unmounted crash");
    tick(5);
    chk(lamp, 1'b0, "R2 lamp stays off");
    mounted = 1'b1;

    // R1 + R9 + R10: crash activation and flash pattern
    crash();
    chk(active, 1'b1, "R1 crash activates");
    chk(buzzer, 1'b1, "R10 buzzer follows active");
    chk(lamp,   1'b1, "R9 lamp on at activation");
    tick(HALF - 1);
    chk(lamp,   1'b1, "R9 lamp end of on phase");
    tick(1);
    chk(lamp,   1'b0, "R9 lamp off phase");
    tick(HALF);
    chk(lamp,   1'b1, "R9 lamp back on");

    // R5: quick panel flick at the limit cancels the crash activation
    flick(0, QUICK);
    chk(active, 1'b0, "R5 panel flick cancels");
    chk(lamp,   1'b0, "R10 lamp off when idle");
    chk(buzzer, 1'b0, "R10 buzzer off when idle");

    // R3 + R7: panel ON dwell past the limit remains a manual activation
    mounted = 1'b0;
    panelOn = 1'b1;
    tick(3);
    chk(active, 1'b1, "R3 panel ON activates");
    tick(QUICK + 1 - 3);
    panelOn = 1'b0;
    tick(3);
    chk(active, 1'b1, "R7 panel long dwell stays active");
    flick(0, 1);
    chk(active, 1'b0, "R5 panel flick minimal dwell");

    // R4 + R6: unit switch
    unitOn = 1'b1;
    tick(3);
    chk(active, 1'b1, "R4 unit ON activates");
    tick(QUICK - 3);
    unitOn = 1'b0;
    tick(3);
    chk(active, 1'b0, "R6 unit flick cancels");
    flick(1, QUICK + 1);
    chk(active, 1'b1, "R7 unit long dwell stays active");
    flick(1, 2);
    chk(active, 1'b0, "R6 unit flick cancels manual");

    // R8: crash during a flick survives the cancel
    mounted = 1'b1;
    unitOn = 1'b1;
    tick(2);
    crashPulse = 1'b1;
    tick(1);
    crashPulse = 1'b0;
    tick(1);
    unitOn = 1'b0;
    tick(3);
    chk(active, 1'b1, "R8 held crash activates after flick");
    flick(0, 2);
    chk(active, 1'b0, "R8 held crash consumed, flick cancels");

    // random mix
    for (int it = 0; it < 24; it++) begin
      int sw = int'($urandom % 2);
      int dwell = 1 + int'($urandom % (2 * QUICK));
      logic m = logic'($urandom % 2);
      mounted = m;
      crash();
      chk(active, m, m ? "R1 random mounted crash" : "R2 random unmounted crash");
      flick(sw, dwell);
      chk(active, expAfterFlick(dwell), sw == 0 ? "R5 R7 random panel flick" : "R6 R7 random unit flick");
      if (active) begin
        flick(1 - sw, 1);
        chk(active, 1'b0, "R5 R6 random cleanup flick");
      end
      tick(int'($urandom % 4));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule